// File: doc/BRIEF.md
# Power Domain Isolation Sequencer

This block switches a switchable domain off and back on when that domain holds registers reached over clock-domain-crossing paths from an always-on domain. A single-cycle request starts a power-down or a power-up. The block then drives three controls in a fixed order: an access-permit signal toward the peer domain, an active-low reset into the target domain, and a power-enable for the target domain. It watches two inputs for this. One says that crossing traffic is still in flight. The other is a power-good acknowledge from the switch. Both arrive asynchronously and pass through two-flop synchronizers before the sequencer looks at them.

Power-down first withdraws the permit. It then waits for the in-flight indication to clear, asserts the domain reset, and only after that removes power. If traffic does not drain within a programmable number of cycles, the sequencer parks in an error state with the permit still withdrawn. Power-up turns power on with reset still held. It waits for power-good and a programmable settle time, releases reset, and restores the permit as the last step. A busy flag covers every step of a sequence. A one-cycle done pulse marks the end of each completed sequence.

Top module: `pwr_iso_seq`

## Requirements
- R1: After `rst_n` is released, `allow`=1, `dom_rst_n`=1, `pwr_en`=1, `busy`=0, `done`=0 and `err`=0.
- R2: A `req_off` pulse while the domain is on lowers `allow` and raises `busy` in the next cycle. In that cycle `dom_rst_n` and `pwr_en` are unchanged.
- R3: The in-flight input is sampled by two flops before the sequencer uses it. While the synchronized value is 1 during draining, `dom_rst_n` stays 1. In the cycle after the sequencer sees it at 0, `dom_rst_n` falls.
- R4: `dom_rst_n` is 0 for at least one cycle with `pwr_en` at 1 before `pwr_en` falls. `pwr_en` falls in the cycle after reset asserts.
- R5: Draining lasts at most `drain_limit`+1 cycles. If the synchronized in-flight value is still 1 in the cycle whose count equals `drain_limit`, the block enters the error state. In that state `err`=1, `allow`=0, `dom_rst_n`=1, `pwr_en`=1 and `busy`=0. If in-flight clears in that same cycle, the drain completes normally.
- R6: A `req_on` pulse while off raises `pwr_en` in the next cycle with `dom_rst_n` held at 0. Once the synchronized power-good is seen at 1, reset stays asserted for a further `settle_cnt`+1 cycles before `dom_rst_n` rises.
- R7: `allow` rises exactly one cycle after `dom_rst_n` rises on power-up. `allow` is never 1 while `dom_rst_n` or `pwr_en` is 0.
- R8: Requests are ignored while `busy` is 1. `req_off` is also ignored while off, and `req_on` is ignored while on.
- R9: `busy` is 1 from the first cycle `allow` is low in a sequence until `allow` returns to 1, until power-off completes, or until the error state is entered.
- R10: `done` is a single-cycle pulse that is high in the first cycle of the fully-on or fully-off condition reached by a sequence.
- R11: In the error state, `req_on` raises `allow` in the next cycle together with `done`. `req_off` restarts draining. If both requests arrive in the same cycle, `req_on` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_off | input | 1 | One-cycle power-down request |
| req_on | input | 1 | One-cycle power-up request |
| drain_limit | input | CNT_W | Drain timeout; the drain may last this many cycles plus one |
| settle_cnt | input | CNT_W | Settle time after power-good; reset is held this many cycles plus one |
| inflight_async | input | 1 | Crossing traffic still in flight (asynchronous) |
| pgood_async | input | 1 | Power-good acknowledge (asynchronous) |
| allow | output | 1 | Access permit toward the peer domain |
| dom_rst_n | output | 1 | Active-low reset of the target domain |
| pwr_en | output | 1 | Power enable of the target domain |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Drain timeout occurred |

## Verification
Two decisions can fall due in the same cycle: the drain completing because in-flight traffic has cleared, and the drain timeout expiring. The bench sweeps the release point of the in-flight input through the cycles around `drain_limit`. One of those releases therefore reaches the synchronizer output exactly in the last allowed cycle. A behavioural model, which lets draining win, judges whether the block went to reset or to the error state. The bench also fires requests in the same cycle as sequence completion. The model checks that these requests are ignored.

// File: rtl/pwr_iso_pkg.sv
package pwr_iso_pkg;
  typedef enum logic [2:0] {
    ST_ON     = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_RST    = 3'd2,
    ST_OFF    = 3'd3,
    ST_PUP    = 3'd4,
    ST_SETTLE = 3'd5,
    ST_REL    = 3'd6,
    ST_ERR    = 3'd7
  } seq_state_e;
endpackage

// File: rtl/pis_sync2.sv
module pis_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pis_counter.sv
module pis_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr | en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pis_fsm.sv
module pis_fsm
  import pwr_iso_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_off,
  input  logic             req_on,
  input  logic             inflight_s,
  input  logic             pgood_s,
  input  logic [CNT_W-1:0] drain_limit,
  input  logic [CNT_W-1:0] settle_cnt,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_en,
  output seq_state_e       state,
  output logic             done
);
  seq_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       moving;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ON:     if (req_off) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (!inflight_s)             state_d = ST_RST;
        else if (cnt == drain_limit) state_d = ST_ERR;
      end
      ST_RST:    state_d = ST_OFF;
      ST_OFF:    if (req_on) state_d = ST_PUP;
      ST_PUP:    if (pgood_s) state_d = ST_SETTLE;
      ST_SETTLE: if (cnt == settle_cnt) state_d = ST_REL;
      ST_REL:    state_d = ST_ON;
      ST_ERR: begin
        if (req_on)       state_d = ST_ON;
        else if (req_off) state_d = ST_DRAIN;
      end
      default:   state_d = ST_ON;
    endcase
  end

  assign moving  = (state_d != state_q);
  assign cnt_clr = moving;
  assign cnt_en  = !moving && (state_q == ST_DRAIN || state_q == ST_SETTLE);
  assign done_d  = moving && (state_d == ST_ON || state_d == ST_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ON;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state = state_q;
  assign done  = done_q;
endmodule

// File: rtl/pwr_iso_seq.sv
module pwr_iso_seq
  import pwr_iso_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_off,
  input  logic             req_on,
  input  logic [CNT_W-1:0] drain_limit,
  input  logic [CNT_W-1:0] settle_cnt,
  input  logic             inflight_async,
  input  logic             pgood_async,
  output logic             allow,
  output logic             dom_rst_n,
  output logic             pwr_en,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] sync_out;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_clr;
  logic              cnt_en;
  seq_state_e        state;

  assign raw_in = {pgood_async, inflight_async};

  pis_sync2 #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  pis_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .cnt(cnt)
  );

  pis_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_off(req_off), .req_on(req_on),
    .inflight_s(sync_out[0]), .pgood_s(sync_out[1]),
    .drain_limit(drain_limit), .settle_cnt(settle_cnt),
    .cnt(cnt), .cnt_clr(cnt_clr), .cnt_en(cnt_en),
    .state(state), .done(done)
  );

  always_comb begin
    allow     = (state == ST_ON);
    dom_rst_n = (state == ST_ON) || (state == ST_DRAIN) ||
                (state == ST_ERR) || (state == ST_REL);
    pwr_en    = (state != ST_OFF);
    busy      = (state == ST_DRAIN) || (state == ST_RST) || (state == ST_PUP) ||
                (state == ST_SETTLE) || (state == ST_REL);
    err       = (state == ST_ERR);
  end
endmodule

// File: rtl/pis_checks.sv
module pis_checks (
  input logic clk,
  input logic rst_n,
  input logic allow,
  input logic dom_rst_n,
  input logic pwr_en,
  input logic busy,
  input logic done
);
  assert_lower_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(allow) |-> busy);

  assert_rst_after_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_rst_n) |-> !allow);

  assert_rst_before_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> (!dom_rst_n && $past(!dom_rst_n) && $past(pwr_en)));

  assert_release_powered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst_n) |-> pwr_en);

  assert_allow_safe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    allow |-> (dom_rst_n && pwr_en));

  assert_allow_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(allow) |-> $past(dom_rst_n));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pwr_iso_seq pis_checks u_chk (
  .clk(clk), .rst_n(rst_n), .allow(allow), .dom_rst_n(dom_rst_n),
  .pwr_en(pwr_en), .busy(busy), .done(done)
);

// File: tb/pwr_iso_seq_bench.sv
module pwr_iso_seq_bench;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_off = 1'b0, req_on = 1'b0;
  logic [CW-1:0] drain_limit = 8'd5, settle_cnt = 8'd3;
  logic inflight_async = 1'b0, pgood_async = 1'b0;
  logic allow, dom_rst_n, pwr_en, busy, done, err;

  int n_cmp = 0, n_bad = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  pwr_iso_seq #(.CNT_W(CW)) u_pwr_iso_seq (
    .clk(clk), .rst_n(rst_n), .req_off(req_off), .req_on(req_on),
    .drain_limit(drain_limit), .settle_cnt(settle_cnt),
    .inflight_async(inflight_async), .pgood_async(pgood_async),
    .allow(allow), .dom_rst_n(dom_rst_n), .pwr_en(pwr_en),
    .busy(busy), .done(done), .err(err)
  );

  // Reference model. Modes: 0 on, 1 drain, 2 reset, 3 off,
  // 4 power-up wait, 5 settle, 6 release, 7 error.
  int  m = 0, k = 0;
  bit  if1, if2, pg1, pg2, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = 0; k = 0; if1 = 0; if2 = 0; pg1 = 0; pg2 = 0; m_done = 0;
    end else begin
      int nm;
      nm = m;
      case (m)
        0: if (req_off) nm = 1;
        1: if (!if2) nm = 2; else if (k == int'(drain_limit)) nm = 7;
        2: nm = 3;
        3: if (req_on) nm = 4;
        4: if (pg2) nm = 5;
        5: if (k == int'(settle_cnt)) nm = 6;
        6: nm = 0;
        default: if (req_on) nm = 0; else if (req_off) nm = 1;
      endcase
      if (nm != m) k = 0; else if (m == 1 || m == 5) k++;
      m_done = (nm != m) && (nm == 0 || nm == 3);
      m = nm;
      if2 = if1; if1 = inflight_async;
      pg2 = pg1; pg1 = pgood_async;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  logic prev_rst_n, prev_pwr;
  always @(negedge clk) begin
    if (running) begin
      chk("R7 allow", allow, m == 0);
      chk("R3 dom_rst_n", dom_rst_n, m == 0 || m == 1 || m == 6 || m == 7);
      chk("R6 pwr_en", pwr_en, m != 3);
      chk("R9 busy", busy, m >= 1 && m <= 6 && m != 3);
      chk("R10 done", done, m_done);
      chk("R5 err", err, m == 7);
      if (prev_pwr && !pwr_en) begin
        chk("R4 reset held before power-off", prev_rst_n, 1'b0);
      end
      prev_rst_n = dom_rst_n; prev_pwr = pwr_en;
    end
  end

  task automatic pulse_off();
    @(negedge clk); req_off = 1'b1;
    @(negedge clk); req_off = 1'b0;
  endtask

  task automatic pulse_on();
    @(negedge clk); req_on = 1'b1;
    @(negedge clk); req_on = 1'b0;
  endtask

  task automatic wait_mode(input int target);
    for (int i = 0; i < 400; i++) begin
      if (m == target) return;
      @(negedge clk);
    end
    n_cmp++; n_bad++;
    $display("FAIL R9: mode %0d actual, %0d expected (timeout)", m, target);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    prev_rst_n = 1'b1; prev_pwr = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 allow", allow, 1'b1);   chk("R1 dom_rst_n", dom_rst_n, 1'b1);
    chk("R1 pwr_en", pwr_en, 1'b1); chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);     chk("R1 err", err, 1'b0);
    running = 1'b1;

    // R8: power-up request while already on is ignored
    pulse_on();
    chk("R8 on ignored allow", allow, 1'b1);
    chk("R8 on ignored busy", busy, 1'b0);

    // R2: clean power-down
    pulse_off();
    chk("R2 allow low", allow, 1'b0);
    chk("R2 busy", busy, 1'b1);
    chk("R2 reset untouched", dom_rst_n, 1'b1);
    chk("R2 power untouched", pwr_en, 1'b1);
    wait_mode(3);
    // R8: power-down request while off is ignored
    pulse_off();
    chk("R8 off ignored pwr_en", pwr_en, 1'b0);
    chk("R8 off ignored busy", busy, 1'b0);

    // R6: power-up with late power-good, requests during busy
    pulse_on();
    chk("R6 power on", pwr_en, 1'b1);
    chk("R6 reset held", dom_rst_n, 1'b0);
    pulse_off();
    pulse_on();
    chk("R8 busy ignores", busy, 1'b1);
    repeat (4) @(negedge clk);
    pgood_async = 1'b1;
    wait_mode(0);
    pgood_async = 1'b0;

    // R3: drain with traffic in flight for several cycles
    inflight_async = 1'b1;
    repeat (3) @(negedge clk);
    pulse_off();
    repeat (2) @(negedge clk);
    chk("R3 reset waits for drain", dom_rst_n, 1'b1);
    inflight_async = 1'b0;
    wait_mode(3);
    pgood_async = 1'b1;
    pulse_on();
    wait_mode(0);

    // R5: timeout into error, retry, then R11 recovery
    inflight_async = 1'b1;
    pulse_off();
    wait_mode(7);
    chk("R5 err", err, 1'b1);
    chk("R5 power kept", pwr_en, 1'b1);
    pulse_off();
    chk("R11 retry busy", busy, 1'b1);
    wait_mode(7);
    @(negedge clk); req_on = 1'b1; req_off = 1'b1;
    @(negedge clk); req_on = 1'b0; req_off = 1'b0;
    chk("R11 allow restored", allow, 1'b1);
    chk("R11 done", done, 1'b1);

    // R5 boundary: sweep release of in-flight around the limit
    for (int lim = 0; lim < 3; lim++) begin
      drain_limit = CW'(lim);
      settle_cnt  = CW'(lim);
      for (int d = 0; d < lim + 5; d++) begin
        inflight_async = 1'b1;
        repeat (3) @(negedge clk);
        pulse_off();
        repeat (d) @(negedge clk);
        inflight_async = 1'b0;
        repeat (lim + 6) @(negedge clk);
        // R8: request landing as completion happens
        pulse_on();
        wait_mode(0);
        repeat (2) @(negedge clk);
      end
    end

    repeat (5) @(negedge clk);
    running = 1'b0;
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    finish_up();
  end
endmodule